// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block is the configuration space of one PCI function, seen from the slave side. A simple register bus reaches it: a strobe, a write flag, a dword address, four byte enables, write data, registered read data and a read-valid flag. The space is 256 bytes, 64 dwords. Only the first 16 dwords, byte offsets 00h to 3Ch, are implemented as the device-independent header. Every access to dwords 16 to 63 reads as zero and changes nothing.

Each bit of the header follows one of three policies. A fixed bit always returns a constant and ignores writes. A sticky status bit is set by a per-bit event input and cleared by writing a one to it. A read/write bit holds the last value written to it. Policy masks, fixed values and reset values are parameters, one 32-bit word per dword. Dword 0 is the identification word. Its upper half is a device code whose lowest hex digit comes from a channel-count parameter, and its lower half is a vendor code.

Reset is asynchronous and active low. The `rst_n` input is expected to be released synchronously to `clk` by the surrounding chip.

Top module: `pci_cfg_header`

## Requirements
- R1: Dword 0 reads as {DEV_PREFIX, channel digit, VENDOR_ID}, which is 32'h7E38A5C3 with the default parameters, and no write changes it.
- R2: The channel digit, bits 19:16 of dword 0, is 1, 2, 4 or 8 when CHANNELS is 32, 64, 128 or 256, so a 32-channel build reads 32'h7E31A5C3.
- R3: A read at dword address 16 to 63 returns 0. A write there changes no header dword, including the dword whose index matches the address's low four bits.
- R4: A read/write bit takes the written data bit only when the byte enable of its lane is set. Enable bit k covers data bits 8k+7:8k. Bits in lanes that are not enabled keep their value.
- R5: Writing 1 to a sticky status bit through an enabled lane clears it. Writing 0, or writing 1 through a disabled lane, leaves it unchanged.
- R6: A 1 on event input bit 32*d+b sets sticky status bit b of dword d in the following cycle. If that event and a write-one clear reach the same bit in the same cycle, the bit is left set.
- R7: A fixed bit always reads its parameter value. Neither writes nor event inputs change fixed bits or read/write bits.
- R8: After reset every read/write and sticky bit holds its reset value. With the defaults, dword 1 reads 32'h02900000, dword 3 reads 32'h00004000 and dword 15 reads 32'h000001AB.
- R9: A read strobe (cfg_stb=1, cfg_we=0) is followed one cycle later by cfg_rvalid=1 with the data in cfg_rdata. A cycle without a read strobe is followed by cfg_rvalid=0.

Default map. Dword 1 has read/write mask 32'h00000157, sticky mask 32'hF9000000 and fixed value 32'h02900000. Dword 2 is fixed at 32'h02800001. Dword 3 has read/write mask 32'h0000FF00 with reset value 32'h00004000. Dword 4 has read/write mask 32'hFFFFF000 with fixed value 32'h00000008. Dword 15 has read/write mask 32'h000000FF, reset value 32'h000000AB and fixed value 32'h00000100. Every other bit is fixed at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_stb | input | 1 | Access strobe, one cycle per access |
| cfg_we | input | 1 | 1 for a write, 0 for a read |
| cfg_addr | input | 6 | Dword address, 0 to 63 |
| cfg_be | input | 4 | Byte lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_set_evt | input | 512 | Per-bit set events for sticky bits, bit 32*d+b for dword d |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a read strobe |

## Verification
Writes of all-ones, all-zeros and mixed patterns go to each kind of dword under full, single-lane and sparse byte enables. Reading back after each write separates a lane-gating fault from a policy-mask fault. Writes to the unimplemented range use an address whose low bits alias a read/write dword, so an incomplete decode shows up as a change in that dword. Event pulses are applied on their own, together with a clear of the same bit, and on fixed and read/write bits. This separates set priority from clear handling and from mask leakage. A second build with 32 channels checks how the identification digit is chosen.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

  localparam int HDR_DW = 16;

  typedef logic [HDR_DW-1:0][31:0] dw_tbl_t;

  function automatic dw_tbl_t def_rw_mask();
    dw_tbl_t t;
    t = '0;
    t[1]  = 32'h0000_0157;
    t[3]  = 32'h0000_FF00;
    t[4]  = 32'hFFFF_F000;
    t[15] = 32'h0000_00FF;
    return t;
  endfunction

  function automatic dw_tbl_t def_w1c_mask();
    dw_tbl_t t;
    t = '0;
    t[1] = 32'hF900_0000;
    return t;
  endfunction

  function automatic dw_tbl_t def_fix_val();
    dw_tbl_t t;
    t = '0;
    t[1]  = 32'h0290_0000;
    t[2]  = 32'h0280_0001;
    t[4]  = 32'h0000_0008;
    t[15] = 32'h0000_0100;
    return t;
  endfunction

  function automatic dw_tbl_t def_rst_val();
    dw_tbl_t t;
    t = '0;
    t[3]  = 32'h0000_4000;
    t[15] = 32'h0000_00AB;
    return t;
  endfunction

  // 32 -> 1, 64 -> 2, 128 -> 4, 256 -> 8
  function automatic logic [3:0] chan_digit(int ch);
    return 4'(ch / 32);
  endfunction

endpackage

// File: rtl/pci_cfg_decode.sv
module pci_cfg_decode #(
  parameter int AW     = 6,
  parameter int NUM_DW = 16,
  parameter int IDX_W  = 4
) (
  input  logic              stb,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [3:0]        be,
  output logic              hdr_hit,
  output logic              rd_req,
  output logic [IDX_W-1:0]  idx,
  output logic [NUM_DW-1:0] wr_sel,
  output logic [31:0]       lane_mask
);

  always_comb begin
    hdr_hit = (addr < AW'(NUM_DW));
    idx     = addr[IDX_W-1:0];
    rd_req  = stb & ~we;
  end

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign lane_mask[8*l +: 8] = {8{be[l]}};
  end

  for (genvar g = 0; g < NUM_DW; g++) begin : g_sel
    assign wr_sel[g] = stb & we & hdr_hit & (idx == IDX_W'(g));
  end

endmodule

// File: rtl/pci_cfg_dword.sv
module pci_cfg_dword #(
  parameter logic [31:0] RW_MASK  = '0,
  parameter logic [31:0] W1C_MASK = '0,
  parameter logic [31:0] FIX_VAL  = '0,
  parameter logic [31:0] RST_VAL  = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] lane_mask,
  input  logic [31:0] wdata,
  input  logic [31:0] set_evt,
  output logic [31:0] value
);

  localparam logic [31:0] STATE_MASK = RW_MASK | W1C_MASK;

  logic [31:0] q;
  logic [31:0] d;
  logic [31:0] rw_nxt;
  logic [31:0] clr;
  logic        ce;

  always_comb begin
    clr    = (wr_en ? (lane_mask & wdata) : 32'h0) & W1C_MASK;
    rw_nxt = wr_en ? ((q & ~lane_mask) | (wdata & lane_mask)) : q;
    // set events are OR-ed after the clear, so a set wins
    d      = (rw_nxt & RW_MASK) | (((q & ~clr) | set_evt) & W1C_MASK);
    ce     = wr_en | (|(set_evt & W1C_MASK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL & STATE_MASK;
    else if (ce) q <= d;
  end

  assign value = (q & STATE_MASK) | (FIX_VAL & ~STATE_MASK);

endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header #(
  parameter int          CHANNELS   = 256,
  parameter logic [15:0] VENDOR_ID  = 16'hA5C3,
  parameter logic [11:0] DEV_PREFIX = 12'h7E3,
  parameter int          NUM_DW     = pci_cfg_pkg::HDR_DW,
  parameter int          CFG_DWORDS = 64,
  parameter logic [NUM_DW-1:0][31:0] RW_MASK  = pci_cfg_pkg::def_rw_mask(),
  parameter logic [NUM_DW-1:0][31:0] W1C_MASK = pci_cfg_pkg::def_w1c_mask(),
  parameter logic [NUM_DW-1:0][31:0] FIX_VAL  = pci_cfg_pkg::def_fix_val(),
  parameter logic [NUM_DW-1:0][31:0] RST_VAL  = pci_cfg_pkg::def_rst_val()
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_stb,
  input  logic                   cfg_we,
  input  logic [5:0]             cfg_addr,
  input  logic [3:0]             cfg_be,
  input  logic [31:0]            cfg_wdata,
  input  logic [NUM_DW*32-1:0]   cfg_set_evt,
  output logic [31:0]            cfg_rdata,
  output logic                   cfg_rvalid
);

  localparam int          AW     = $clog2(CFG_DWORDS);
  localparam int          IDX_W  = $clog2(NUM_DW);
  localparam logic [31:0] ID_VAL = {DEV_PREFIX, pci_cfg_pkg::chan_digit(CHANNELS), VENDOR_ID};

  logic              hdr_hit;
  logic              rd_req;
  logic [IDX_W-1:0]  idx;
  logic [NUM_DW-1:0] wr_sel;
  logic [31:0]       lane_mask;
  logic [NUM_DW-1:0][31:0] dw_val;
  logic [31:0]       rdata_nxt;

  pci_cfg_decode #(.AW(AW), .NUM_DW(NUM_DW), .IDX_W(IDX_W)) u_dec (
    .stb       (cfg_stb),
    .we        (cfg_we),
    .addr      (cfg_addr[AW-1:0]),
    .be        (cfg_be),
    .hdr_hit   (hdr_hit),
    .rd_req    (rd_req),
    .idx       (idx),
    .wr_sel    (wr_sel),
    .lane_mask (lane_mask)
  );

  for (genvar g = 0; g < NUM_DW; g++) begin : g_dw
    if (g == 0) begin : g_id
      pci_cfg_dword #(
        .RW_MASK ('0), .W1C_MASK('0), .FIX_VAL(ID_VAL), .RST_VAL('0)
      ) u_dw (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[g]), .lane_mask(lane_mask),
        .wdata(cfg_wdata), .set_evt(cfg_set_evt[32*g +: 32]), .value(dw_val[g])
      );
    end else begin : g_gen
      pci_cfg_dword #(
        .RW_MASK (RW_MASK[g]), .W1C_MASK(W1C_MASK[g]),
        .FIX_VAL (FIX_VAL[g]), .RST_VAL (RST_VAL[g])
      ) u_dw (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[g]), .lane_mask(lane_mask),
        .wdata(cfg_wdata), .set_evt(cfg_set_evt[32*g +: 32]), .value(dw_val[g])
      );
    end
  end

  always_comb begin
    rdata_nxt = hdr_hit ? dw_val[idx] : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rdata  <= '0;
      cfg_rvalid <= 1'b0;
    end else begin
      cfg_rvalid <= rd_req;
      if (rd_req) cfg_rdata <= rdata_nxt;
    end
  end

endmodule

// File: rtl/pci_cfg_header_chk.sv
module pci_cfg_header_chk #(
  parameter logic [15:0] VENDOR = 16'hA5C3,
  parameter int          NUM_DW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_stb,
  input logic                 cfg_we,
  input logic [5:0]           cfg_addr,
  input logic [3:0]           cfg_be,
  input logic [31:0]          cfg_wdata,
  input logic [NUM_DW*32-1:0] cfg_set_evt,
  input logic [31:0]          cfg_rdata,
  input logic                 cfg_rvalid
);

  a_r9_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stb && !cfg_we) |=> cfg_rvalid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_stb && !cfg_we) |=> !cfg_rvalid);

  a_r3_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stb && !cfg_we && cfg_addr >= 6'(NUM_DW)) |=> (cfg_rdata == 32'h0));

  a_r1_vendor: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stb && !cfg_we && cfg_addr == 6'd0) |=> (cfg_rdata[15:0] == VENDOR));

  a_r5_clear_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stb && cfg_we && cfg_addr == 6'd1 && cfg_be[3] && cfg_wdata[31] && !cfg_set_evt[63])
      ##1 (cfg_stb && !cfg_we && cfg_addr == 6'd1) |=> !cfg_rdata[31]);

  a_r6_set_seen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_set_evt[59] ##1 (cfg_stb && !cfg_we && cfg_addr == 6'd1) |=> cfg_rdata[27]);

endmodule

bind pci_cfg_header pci_cfg_header_chk #(.VENDOR(VENDOR_ID), .NUM_DW(NUM_DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_set_evt(cfg_set_evt),
  .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid)
);

// File: tb/pci_cfg_header_test.sv
module pci_cfg_header_test;

  typedef struct packed {
    logic        wr;
    logic [5:0]  a;
    logic [3:0]  be;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd0,  4'hF, 32'h0,        32'h7E38A5C3, 4'd1}, // R1
    '{1'b1, 6'd0,  4'hF, 32'hFFFFFFFF, 32'h0,        4'd1}, // R1
    '{1'b0, 6'd0,  4'hF, 32'h0,        32'h7E38A5C3, 4'd1}, // R1
    '{1'b0, 6'd1,  4'hF, 32'h0,        32'h02900000, 4'd8}, // R8
    '{1'b0, 6'd3,  4'hF, 32'h0,        32'h00004000, 4'd8}, // R8
    '{1'b0, 6'd15, 4'hF, 32'h0,        32'h000001AB, 4'd8}, // R8
    '{1'b1, 6'd3,  4'h2, 32'hFFFFFFFF, 32'h0,        4'd4}, // R4
    '{1'b0, 6'd3,  4'hF, 32'h0,        32'h0000FF00, 4'd4}, // R4
    '{1'b1, 6'd3,  4'hD, 32'h0,        32'h0,        4'd4}, // R4
    '{1'b0, 6'd3,  4'hF, 32'h0,        32'h0000FF00, 4'd4}, // R4
    '{1'b1, 6'd15, 4'h1, 32'h12345678, 32'h0,        4'd4}, // R4
    '{1'b0, 6'd15, 4'hF, 32'h0,        32'h00000178, 4'd4}, // R4
    '{1'b1, 6'd15, 4'hE, 32'h0,        32'h0,        4'd7}, // R7
    '{1'b0, 6'd15, 4'hF, 32'h0,        32'h00000178, 4'd7}, // R7
    '{1'b1, 6'd4,  4'hF, 32'h12345678, 32'h0,        4'd4}, // R4
    '{1'b0, 6'd4,  4'hF, 32'h0,        32'h12345008, 4'd4}, // R4
    '{1'b1, 6'd4,  4'h8, 32'h0,        32'h0,        4'd4}, // R4
    '{1'b0, 6'd4,  4'hF, 32'h0,        32'h00345008, 4'd4}, // R4
    '{1'b1, 6'd2,  4'hF, 32'hFFFFFFFF, 32'h0,        4'd7}, // R7
    '{1'b0, 6'd2,  4'hF, 32'h0,        32'h02800001, 4'd7}, // R7
    '{1'b1, 6'd19, 4'hF, 32'h0,        32'h0,        4'd3}, // R3
    '{1'b0, 6'd19, 4'hF, 32'h0,        32'h0,        4'd3}, // R3
    '{1'b0, 6'd63, 4'hF, 32'h0,        32'h0,        4'd3}, // R3
    '{1'b0, 6'd3,  4'hF, 32'h0,        32'h0000FF00, 4'd3}, // R3
    '{1'b1, 6'd1,  4'hF, 32'hFFFFFFFF, 32'h0,        4'd5}, // R5
    '{1'b0, 6'd1,  4'hF, 32'h0,        32'h02900157, 4'd5}  // R5
  };

  logic         clk;
  logic         rst_n;
  logic         cfg_stb;
  logic         cfg_we;
  logic [5:0]   cfg_addr;
  logic [3:0]   cfg_be;
  logic [31:0]  cfg_wdata;
  logic [511:0] cfg_set_evt;
  logic [31:0]  cfg_rdata, rdata32;
  logic         cfg_rvalid, rvalid32;

  int total = 0;
  int bad   = 0;
  logic [31:0] rd;
  logic        rv;

  pci_cfg_header uut (
    .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_set_evt(cfg_set_evt),
    .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid)
  );

  pci_cfg_header #(.CHANNELS(32)) uut_c32 (
    .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_set_evt(cfg_set_evt),
    .cfg_rdata(rdata32), .cfg_rvalid(rvalid32)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic do_write(logic [5:0] a, logic [3:0] be, logic [31:0] d);
    cfg_stb = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_stb = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic do_read(logic [5:0] a);
    cfg_stb = 1'b1; cfg_we = 1'b0; cfg_addr = a;
    @(negedge clk);
    cfg_stb = 1'b0;
    rd = cfg_rdata;
    rv = cfg_rvalid;
  endtask

  task automatic pulse_evt(logic [511:0] e);
    cfg_set_evt = e;
    @(negedge clk);
    cfg_set_evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_stb = 1'b0; cfg_we = 1'b0; cfg_addr = '0;
    cfg_be = '0; cfg_wdata = '0; cfg_set_evt = '0;
    repeat (3) @(negedge clk);
    check("R8 rvalid in reset", {31'h0, cfg_rvalid}, 32'h0);
    check("R8 rdata in reset", cfg_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        do_write(VECS[i].a, VECS[i].be, VECS[i].d);
      end else begin
        do_read(VECS[i].a);
        check($sformatf("R%0d vec %0d", VECS[i].req, i), rd, VECS[i].exp);
      end
    end

    // R9: read valid timing
    do_read(6'd2);
    check("R9 rvalid after read", {31'h0, rv}, 32'h1);
    @(negedge clk);
    check("R9 rvalid idle", {31'h0, cfg_rvalid}, 32'h0);
    do_write(6'd15, 4'h0, 32'h0);
    check("R9 rvalid after write", {31'h0, cfg_rvalid}, 32'h0);

    // R2: 32-channel build identification digit
    do_read(6'd0);
    check("R2 id 32ch", rdata32, 32'h7E31A5C3);
    check("R2 id 256ch", rd, 32'h7E38A5C3);

    // R6: events set sticky bits 31 and 24 of dword 1
    pulse_evt(512'h1 << 63 | 512'h1 << 56);
    do_read(6'd1);
    check("R6 event set", rd, 32'h83900157);
    do_write(6'd1, 4'h8, 32'h0);           // R5 write zero
    do_read(6'd1);
    check("R5 write zero keeps", rd, 32'h83900157);
    do_write(6'd1, 4'h8, 32'h80000000);    // R5 clear bit 31
    do_read(6'd1);
    check("R5 write one clears", rd, 32'h03900157);
    do_write(6'd1, 4'h4, 32'h01000000);    // R5 lane 3 disabled
    do_read(6'd1);
    check("R5 disabled lane keeps", rd, 32'h03900157);
    // R6: set and clear in the same cycle, set wins
    cfg_set_evt = 512'h1 << 56;
    do_write(6'd1, 4'h8, 32'h01000000);
    cfg_set_evt = '0;
    do_read(6'd1);
    check("R6 set wins over clear", rd, 32'h03900157);
    do_write(6'd1, 4'h8, 32'h01000000);
    do_read(6'd1);
    check("R5 clear after collision", rd, 32'h02900157);

    // R7: events on fixed and read/write bits have no effect
    pulse_evt({32'hFFFFFFFF, 32'hFFFFFFFF} << 64 | {32'hFFFFFFFF, 32'h0} << 448);
    do_read(6'd2);
    check("R7 fixed ignores event", rd, 32'h02800001);
    do_read(6'd3);
    check("R7 rw ignores event", rd, 32'h0000FF00);
    do_read(6'd15);
    check("R7 rw dword15 ignores event", rd, 32'h00000178);

    // R8: reset in mid-run restores reset values
    rst_n = 1'b0;
    #5;
    check("R8 async reset rvalid", {31'h0, cfg_rvalid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(6'd1);
    check("R8 dword1 after reset", rd, 32'h02900000);
    do_read(6'd3);
    check("R8 dword3 after reset", rd, 32'h00004000);
    do_read(6'd15);
    check("R8 dword15 after reset", rd, 32'h000001AB);
    do_read(6'd4);
    check("R8 dword4 after reset", rd, 32'h00000008);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule